// File: doc/BRIEF.md
# Pseudo-Float Output Normalizer Buffer

This block sits between a time-multiplexed voice datapath and an external DAC whose output passes through a switchable attenuator. Each 15-bit two's-complement voice sample is turned into a 12-bit mantissa and a one-hot scale code. The scale code selects a division of 1, 2, 4 or 8 in the attenuator, which cancels the left shift applied to the mantissa, so small samples keep more of their low-order bits.

Normalized results for sixteen voices circulate in a sixteen-stage loop. The loop moves one stage for each slot tick, and a voice is rewritten only when a load is requested at its tick. Two output latches take turns. The idle latch captures the next voice in an interleaved presentation order as that voice leaves the loop, and then becomes the latch that drives the DAC. A hold strobe pulses for the latch that has just taken over, on the SH1 pin for the first latch and on the SH2 pin for the second. A test mode turns normalization off.

Top module: `pfloat_out_buf`

## Requirements
- R1: While reset is asserted and after it is released, before any capture, da_o is 0, sf_o is 4'b0001, and sh1_o and sh2_o are both 0. Every loop entry resets to mantissa 0 with scale code 4'b0001.
- R2: The normalizer counts L, the number of leading bits equal to bit 14, including bit 14 itself. The left shift is 3 when L is 5 or more, 2 when L is 4, 1 when L is 3, and 0 when L is 2 or less.
- R3: The mantissa is bits 14 down to 3 of the sample after the left shift.
- R4: The scale code is one-hot, with bit k set for a shift of k. Bit 0 means divide by 1, bit 1 by 2, bit 2 by 4 and bit 3 by 8.
- R5: While tmode_i is 1, the shift is 0, the scale code is 4'b0001 and the mantissa is sample bits 14 down to 3.
- R6: A voice counter is 0 after reset and advances by one, modulo 16, on each cycle with tick_i high. A cycle with tick_i and ld_i both high replaces the entry of the voice named by the counter with the normalized sample. Any other tick leaves every stored entry unchanged.
- R7: Voices, numbered from 0, are captured in the repeating order 0, 12, 4, 10, 2, 14, 6, 9, 1, 13, 5, 11, 3, 15, 7, 8. A capture happens on a tick whose voice counter equals the next voice in that order. It takes the stored entry as it was before that tick, and da_o and sf_o show the captured entry from the clock edge of that tick. Between captures they hold their value.
- R8: Each capture raises exactly one strobe for one cycle, in the same cycle that the new value appears. The strobes alternate, starting with sh1_o, and they are never high together.
- R9: ld_i has no effect in a cycle with tick_i low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_i | input | 15 | Two's-complement voice sample |
| ld_i | input | 1 | Store the sample for the current voice on this tick |
| tick_i | input | 1 | Slot timing: advances the loop by one voice |
| tmode_i | input | 1 | Test mode: no normalization |
| da_o | output | 12 | Mantissa to the DAC |
| sf_o | output | 4 | One-hot attenuator select |
| sh1_o | output | 1 | Hold strobe for the first latch |
| sh2_o | output | 1 | Hold strobe for the second latch |

## Verification
The normalizer is combinational, so its mantissa and scale code are due in the same cycle as the sample. The bench checks them there, on a separate normalizer instance that is fed the boundary values and every leading-bit count. Through the top, a captured entry and its strobe are due one edge after the capturing tick. An entry that is loaded shows up only at a later capture of that voice. The bench therefore applies inputs on the falling edge and updates its model as the next rising edge would. It compares da_o, sf_o and both strobes at the following falling edge, after that one register stage.

// File: rtl/pfo_pkg.sv
package pfo_pkg;
  localparam int VOICES = 16;
  localparam int VW     = 4;

  // interleaved presentation sequence, position -> voice
  function automatic logic [VW-1:0] pfo_order(input logic [VW-1:0] pos);
    logic [VW-1:0] v;
    case (pos)
      4'd0:  v = 4'd0;   4'd1:  v = 4'd12;  4'd2:  v = 4'd4;   4'd3:  v = 4'd10;
      4'd4:  v = 4'd2;   4'd5:  v = 4'd14;  4'd6:  v = 4'd6;   4'd7:  v = 4'd9;
      4'd8:  v = 4'd1;   4'd9:  v = 4'd13;  4'd10: v = 4'd5;   4'd11: v = 4'd11;
      4'd12: v = 4'd3;   4'd13: v = 4'd15;  4'd14: v = 4'd7;   default: v = 4'd8;
    endcase
    return v;
  endfunction
endpackage

// File: rtl/pfo_norm.sv
module pfo_norm #(
  parameter int SMP_W  = 15,
  parameter int MANT_W = 12,
  localparam int SH_MAX = SMP_W - MANT_W,
  localparam int SF_W   = SH_MAX + 1,
  localparam int CW     = $clog2(SMP_W + 1),
  localparam int SHW    = $clog2(SH_MAX + 1)
) (
  input  logic [SMP_W-1:0]  smp_i,
  input  logic              tmode_i,
  output logic [MANT_W-1:0] mant_o,
  output logic [SF_W-1:0]   sf_o
);
  logic [CW-1:0]    cnt;
  logic             run;
  logic [SHW-1:0]   sh;
  logic [SMP_W-1:0] shifted;

  // run length of sign copies from the top
  always_comb begin
    cnt = CW'(1);
    run = 1'b1;
    for (int i = SMP_W - 2; i >= 0; i--) begin
      if (run && (smp_i[i] == smp_i[SMP_W-1])) cnt = cnt + CW'(1);
      else                                      run = 1'b0;
    end
  end

  always_comb begin
    if (tmode_i)                        sh = '0;
    else if (cnt >= CW'(SH_MAX + 2))    sh = SHW'(SH_MAX);
    else if (cnt >= CW'(2))             sh = SHW'(cnt - CW'(2));
    else                                sh = '0;
  end

  assign shifted = smp_i << sh;
  assign mant_o  = shifted[SMP_W-1 -: MANT_W];
  assign sf_o    = SF_W'(1) << sh;

  always_comb begin
    a_r3_sign_kept: assert (mant_o[MANT_W-1] == smp_i[SMP_W-1]);
    if (tmode_i) begin
      a_r5_test_no_scale: assert (mant_o == smp_i[SMP_W-1 -: MANT_W]);
    end
  end
endmodule

// File: rtl/pfo_ring.sv
module pfo_ring
  import pfo_pkg::*;
#(
  parameter int             EW      = 16,
  parameter logic [EW-1:0]  RST_VAL = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_i,
  input  logic          ld_i,
  input  logic [EW-1:0] wdata_i,
  output logic [EW-1:0] head_o,
  output logic [VW-1:0] hv_o
);
  logic [EW-1:0] stg_q [VOICES];
  logic [EW-1:0] stg_d [VOICES];
  logic [VW-1:0] hv_q, hv_d;

  always_comb begin
    stg_d[0] = ld_i ? wdata_i : stg_q[VOICES-1];
    for (int i = 1; i < VOICES; i++) stg_d[i] = stg_q[i-1];
    hv_d = hv_q + VW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < VOICES; i++) stg_q[i] <= RST_VAL;
      hv_q <= '0;
    end else if (tick_i) begin
      for (int i = 0; i < VOICES; i++) stg_q[i] <= stg_d[i];
      hv_q <= hv_d;
    end
  end

  assign head_o = stg_q[VOICES-1];
  assign hv_o   = hv_q;

  a_r6_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_i |=> ($stable(head_o) && $stable(hv_o)));
  a_r6_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    tick_i |=> (hv_o == VW'($past(hv_o) + 1)));
endmodule

// File: rtl/pfo_unload.sv
module pfo_unload
  import pfo_pkg::*;
#(
  parameter int             EW      = 16,
  parameter logic [EW-1:0]  RST_VAL = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_i,
  input  logic [VW-1:0] hv_i,
  input  logic [EW-1:0] head_i,
  output logic [EW-1:0] dac_o,
  output logic          sh1_o,
  output logic          sh2_o
);
  logic [EW-1:0] lat_a_q, lat_a_d, lat_b_q, lat_b_d;
  logic [VW-1:0] ptr_q, ptr_d;
  logic          sel_q, sel_d;   // 1: second latch drives
  logic          sh1_q, sh1_d, sh2_q, sh2_d;
  logic          cap;

  assign cap = tick_i && (hv_i == pfo_order(ptr_q));

  always_comb begin
    lat_a_d = lat_a_q;
    lat_b_d = lat_b_q;
    ptr_d   = ptr_q;
    sel_d   = sel_q;
    sh1_d   = 1'b0;
    sh2_d   = 1'b0;
    if (cap) begin
      ptr_d = ptr_q + VW'(1);
      sel_d = ~sel_q;
      if (sel_q) begin
        lat_a_d = head_i;
        sh1_d   = 1'b1;
      end else begin
        lat_b_d = head_i;
        sh2_d   = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_a_q <= RST_VAL;
      lat_b_q <= RST_VAL;
      ptr_q   <= '0;
      sel_q   <= 1'b1;
      sh1_q   <= 1'b0;
      sh2_q   <= 1'b0;
    end else begin
      lat_a_q <= lat_a_d;
      lat_b_q <= lat_b_d;
      ptr_q   <= ptr_d;
      sel_q   <= sel_d;
      sh1_q   <= sh1_d;
      sh2_q   <= sh2_d;
    end
  end

  assign dac_o = sel_q ? lat_b_q : lat_a_q;
  assign sh1_o = sh1_q;
  assign sh2_o = sh2_q;

  a_r8_never_both: assert property (@(posedge clk) disable iff (!rst_n)
    !(sh1_o && sh2_o));
  a_r8_sh1_single: assert property (@(posedge clk) disable iff (!rst_n)
    sh1_o |=> !sh1_o);
  a_r8_sh2_single: assert property (@(posedge clk) disable iff (!rst_n)
    sh2_o |=> !sh2_o);
  a_r7_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
    !(sh1_o || sh2_o) |-> $stable(dac_o));
endmodule

// File: rtl/pfloat_out_buf.sv
module pfloat_out_buf
  import pfo_pkg::*;
#(
  parameter int SMP_W  = 15,
  parameter int MANT_W = 12,
  localparam int SF_W  = SMP_W - MANT_W + 1,
  localparam int EW    = MANT_W + SF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SMP_W-1:0]  smp_i,
  input  logic              ld_i,
  input  logic              tick_i,
  input  logic              tmode_i,
  output logic [MANT_W-1:0] da_o,
  output logic [SF_W-1:0]   sf_o,
  output logic              sh1_o,
  output logic              sh2_o
);
  localparam logic [EW-1:0] RST_VAL = {{MANT_W{1'b0}}, SF_W'(1)};

  logic [MANT_W-1:0] mant;
  logic [SF_W-1:0]   sf;
  logic [EW-1:0]     head, dac;
  logic [VW-1:0]     hv;

  pfo_norm #(.SMP_W(SMP_W), .MANT_W(MANT_W)) i_norm (
    .smp_i(smp_i), .tmode_i(tmode_i), .mant_o(mant), .sf_o(sf));

  pfo_ring #(.EW(EW), .RST_VAL(RST_VAL)) i_ring (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .ld_i(ld_i),
    .wdata_i({mant, sf}), .head_o(head), .hv_o(hv));

  pfo_unload #(.EW(EW), .RST_VAL(RST_VAL)) i_unload (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .hv_i(hv), .head_i(head),
    .dac_o(dac), .sh1_o(sh1_o), .sh2_o(sh2_o));

  assign da_o = dac[EW-1 -: MANT_W];
  assign sf_o = dac[SF_W-1:0];

  a_r4_sf_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(sf_o) == 1);
endmodule

// File: tb/test_pfloat_out_buf.sv
`timescale 1ns/1ps
module test_pfloat_out_buf;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [14:0] smp;
  logic        ld, tick, tmode;
  logic [11:0] da;
  logic [3:0]  sf;
  logic        sh1, sh2;
  logic [14:0] n_smp;
  logic        n_tm;
  logic [11:0] n_mant;
  logic [3:0]  n_sf;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  pfloat_out_buf i_pfloat_out_buf (
    .clk(clk), .rst_n(rst_n), .smp_i(smp), .ld_i(ld), .tick_i(tick),
    .tmode_i(tmode), .da_o(da), .sf_o(sf), .sh1_o(sh1), .sh2_o(sh2));

  pfo_norm i_norm_only (.smp_i(n_smp), .tmode_i(n_tm), .mant_o(n_mant), .sf_o(n_sf));

  // expected {mantissa, scale} per R2..R5
  function automatic logic [15:0] ref_norm(input logic [14:0] s, input logic t);
    int run = 0;
    int k;
    logic [14:0] x;
    for (int i = 14; i >= 0; i--)
      if (s[i] == s[14] && run == 14 - i) run++;
    k = t ? 0 : (run >= 5 ? 3 : (run >= 2 ? run - 2 : 0));
    x = s << k;
    return {x[14:3], 4'(1 << k)};
  endfunction

  function automatic logic [3:0] seq_voice(input int p);
    int tbl [16] = '{0, 12, 4, 10, 2, 14, 6, 9, 1, 13, 5, 11, 3, 15, 7, 8};
    return 4'(tbl[p % 16]);
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // model state
  logic [15:0] mem [16];
  int          m_hv, m_ptr;
  logic [15:0] e_dac;
  logic        e_sh1, e_sh2;

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [14:0] dir [10] = '{15'h0000, 15'h7FFF, 15'h3FFF, 15'h4000,
                              15'h1000, 15'h0800, 15'h0400, 15'h0200,
                              15'h6000, 15'h7C00};
    void'($urandom(32'd5179));
    rst_n = 1'b0; smp = '0; ld = 0; tick = 0; tmode = 0;
    n_smp = '0; n_tm = 0;

    // directed normalizer corner cases (combinational)
    for (int t = 0; t < 2; t++) begin
      for (int i = 0; i < 10; i++) begin
        logic [15:0] e;
        n_smp = dir[i]; n_tm = t[0];
        #1;
        e = ref_norm(dir[i], t[0]);
        chk(t ? "R5" : "R2/R3", "mantissa", int'(n_mant), int'(e[15:4]));
        chk(t ? "R5" : "R4", "scale", int'(n_sf), int'(e[3:0]));
      end
    end

    // reset state, R1
    @(negedge clk);
    chk("R1", "da in reset", int'(da), 0);
    chk("R1", "sf in reset", int'(sf), 1);
    chk("R1", "strobes in reset", int'({sh1, sh2}), 0);
    for (int v = 0; v < 16; v++) mem[v] = 16'h0001;
    m_hv = 0; m_ptr = 0; e_dac = 16'h0001; e_sh1 = 0; e_sh2 = 0;
    rst_n = 1'b1;

    for (int c = 0; c < 4000; c++) begin
      @(negedge clk);
      // outputs after the previous rising edge: R6 R7 R8 R9
      chk("R7", "da", int'(da), int'(e_dac[15:4]));
      chk("R7", "sf", int'(sf), int'(e_dac[3:0]));
      chk("R8", "strobes", int'({sh1, sh2}), int'({e_sh1, e_sh2}));
      // new stimulus
      tick  = ($urandom % 4) != 0;
      ld    = ($urandom % 2) != 0;
      tmode = ($urandom % 10) == 0;
      case ($urandom % 4)
        0: smp = dir[$urandom % 10];
        1: smp = 15'($urandom);
        default: begin
          smp = 15'($urandom) >> ($urandom % 15);
          if ($urandom % 2) smp = ~smp;
        end
      endcase
      // model the coming rising edge
      e_sh1 = 0; e_sh2 = 0;
      if (tick) begin
        if (4'(m_hv) == seq_voice(m_ptr)) begin
          e_dac = mem[m_hv];
          if (m_ptr % 2 == 0) e_sh1 = 1; else e_sh2 = 1;
          m_ptr++;
        end
        if (ld) mem[m_hv] = ref_norm(smp, tmode);
        m_hv = (m_hv + 1) % 16;
      end
    end
    summary();
  end
endmodule